// File: doc/BRIEF.md
# Quasi-Bidirectional 16-bit Port Expander

This block is the serial-bus data path of an I/O expander whose lines have no direction register. An I2C master addresses it and then either writes bytes that land on the port latches, or reads bytes that carry the present pin levels. Bytes are taken and returned in pairs. The lower port is always first and the upper port second. The order keeps alternating for as long as the transfer runs.

Each line has three signals. The first is a low driver, enabled while the line's latch holds 0. The second is a strong pull-up enable, which pulses when a 1 is written. The third is the observed pin level. A line latched at 1 is held up only weakly, so an outside device can pull it down and it works as an input. The bit-level I2C receiver and transmitter are included. They sample SCL and SDA with the system clock. SDA is pulled low through an open-drain enable.

Top module: `qbx_expander`

## Requirements
- R1: After reset every port latch holds 1, so drive_low_o is all 0. strong_pu_o is all 0 and sda_oe_o is 0.
- R2: An address byte is acknowledged only when its upper 7 bits equal SLAVE_ADDR. Bit 0 is the read/write flag, with 0 meaning write. A transfer to any other address gets no acknowledge, SDA stays released, and the ports do not change.
- R3: In a write, the first data byte sets port 0 and the second sets port 1. Bit n of a byte maps to line n of port 0 or to line 8+n of port 1.
- R4: A written byte changes its port lines only at the SCL falling edge that ends its acknowledge bit. The first byte of a pair is applied before the second byte arrives.
- R5: A write may hold any number of bytes. The third byte goes to port 0 again, the fourth to port 1, and so on. Each one overwrites the earlier value of its port.
- R6: When a byte is applied, strong_pu_o rises for every line of that port whose new bit is 1. It stays high until the next SCL falling edge and then drops. A line written 0 never gets a strong pull-up.
- R7: drive_low_o for a line is 1 exactly when its latch holds 0. Such a line therefore reads back as 0.
- R8: In a read, the bytes carry pin_i levels, port 0 first and then port 1, alternating, most significant bit first. Bytes keep coming while the master acknowledges. After a master not-acknowledge, SDA is released.
- R9: A STOP or a repeated START returns the byte pointer to port 0.
- R10: A read byte holds the pin levels sampled when it was loaded, which is at the SCL falling edge that ends the preceding acknowledge. A pin change after loading shows up only in a later byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pin_i | input | 8*NUM_PORTS | Observed level of each line |
| drive_low_o | output | 8*NUM_PORTS | 1 enables the strong low driver of a line |
| strong_pu_o | output | 8*NUM_PORTS | 1 enables the brief strong pull-up of a line |

## Verification
The bench builds the block with SLAVE_ADDR = 7'h24, NUM_PORTS = 2 and SYNC_STAGES = 2, which gives sixteen lines. With two ports, a transfer of three or four bytes exercises both the wrap of the pointer and the overwrite of a port within one transfer. The two-stage input synchronizer adds a delay of a few clocks. The bench keeps each SCL half period at eight clocks, so that delay always falls within one phase. The bench models the open-drain pins and the wired-AND SDA line. This lets it check that a line written 0 reads back 0.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } qbx_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle bus is high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/qbx_bus_fsm.sv
module qbx_bus_fsm
  import qbx_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h24,
  parameter int NUM_PORTS = 2,
  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LINES = NUM_PORTS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [LINES-1:0]  pin_i,
  output logic              sda_oe_o,
  output logic              scl_fall_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_port_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output qbx_state_e        state_o
);
  qbx_state_e        state_q;
  logic              scl_q, sda_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              rw_q, mack_q;
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic [BYTE_W-1:0] pin_byte;
  logic              start_det, stop_det, scl_rise, scl_fall;

  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign ptr_nxt   = (ptr_q == PTR_W'(NUM_PORTS - 1)) ? '0 : ptr_q + 1'b1;
  assign pin_byte  = pin_i[BYTE_W*int'(ptr_q) +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      ptr_q     <= '0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      ptr_q     <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            if (state_q == ST_WR) begin
              state_q <= ST_WR_ACK;
            end else if (shreg_q[7:1] == SLAVE_ADDR) begin
              rw_q    <= shreg_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              shreg_q <= pin_byte;
              ptr_q   <= ptr_nxt;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            ptr_q     <= ptr_nxt;
            bit_cnt_q <= '0;
            state_q   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              state_q <= ST_RD_ACK;
            end else begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_q   <= pin_byte;  // sampled at load time
              ptr_q     <= ptr_nxt;
              bit_cnt_q <= '0;
              state_q   <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                      ((state_q == ST_RD) && !shreg_q[BYTE_W-1]);
  assign scl_fall_o = scl_fall;
  assign wr_en_o    = (state_q == ST_WR_ACK) && scl_fall && !start_det && !stop_det;
  assign wr_port_o  = ptr_q;
  assign wr_data_o  = shreg_q;
  assign state_o    = state_q;
endmodule

// File: rtl/qbx_port_bank.sv
module qbx_port_bank
  import qbx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LINES = NUM_PORTS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_port_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              scl_fall_i,
  output logic [LINES-1:0]  latch_o,
  output logic [LINES-1:0]  strong_pu_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BYTE_W-1:0] latch_q, pu_q;
    logic              sel;

    assign sel = wr_en_i && (wr_port_i == PTR_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        latch_q <= '1;
        pu_q    <= '0;
      end else if (sel) begin
        latch_q <= wr_data_i;
        pu_q    <= wr_data_i;  // boost only lines written high
      end else if (scl_fall_i) begin
        pu_q <= '0;
      end
    end

    assign latch_o[p*BYTE_W +: BYTE_W]     = latch_q;
    assign strong_pu_o[p*BYTE_W +: BYTE_W] = pu_q;
  end
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
  import qbx_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h24,
  parameter int         NUM_PORTS   = 2,
  parameter int         SYNC_STAGES = 2,
  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LINES = NUM_PORTS * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] drive_low_o,
  output logic [LINES-1:0] strong_pu_o
);
  logic              scl_s, sda_s;
  logic              scl_fall, wr_en;
  logic [PTR_W-1:0]  wr_port;
  logic [BYTE_W-1:0] wr_data;
  logic [LINES-1:0]  latch;
  qbx_state_e        state;

  qbx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );
  qbx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  qbx_bus_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_PORTS(NUM_PORTS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .pin_i     (pin_i),
    .sda_oe_o  (sda_oe_o),
    .scl_fall_o(scl_fall),
    .wr_en_o   (wr_en),
    .wr_port_o (wr_port),
    .wr_data_o (wr_data),
    .state_o   (state)
  );

  qbx_port_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_port_i  (wr_port),
    .wr_data_i  (wr_data),
    .scl_fall_i (scl_fall),
    .latch_o    (latch),
    .strong_pu_o(strong_pu_o)
  );

  assign drive_low_o = ~latch;
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk
  import qbx_pkg::*;
#(
  parameter int LINES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_fall,
  input logic             wr_en,
  input qbx_state_e       state,
  input logic             sda_oe_o,
  input logic [LINES-1:0] drive_low_o,
  input logic [LINES-1:0] strong_pu_o
);
  AST_PU_DROPS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall && !wr_en) |=> (strong_pu_o == '0));  // R6

  AST_PU_ONLY_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strong_pu_o & ~$past(strong_pu_o)) != '0) |-> $past(wr_en));  // R6

  AST_PORTS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(drive_low_o));  // R4

  AST_NO_PU_ON_LOW_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strong_pu_o & drive_low_o) == '0);  // R7

  AST_SDA_FREE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);  // R2
endmodule

bind qbx_expander qbx_expander_chk #(.LINES(LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall   (scl_fall),
  .wr_en      (wr_en),
  .state      (state),
  .sda_oe_o   (sda_oe_o),
  .drive_low_o(drive_low_o),
  .strong_pu_o(strong_pu_o)
);

// File: tb/qbx_expander_tb.sv
module qbx_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h24;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [15:0] ext_pins = 16'hFFFF;
  logic        sda_oe;
  logic [15:0] drive_low, strong_pu, pin;
  logic        sda_line;
  int          n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign pin      = ext_pins & ~drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbx_expander #(.SLAVE_ADDR(ADDR), .NUM_PORTS(2), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .pin_i      (pin),
    .drive_low_o(drive_low),
    .strong_pu_o(strong_pu)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wait_clk(Q);
    scl = 1'b1; wait_clk(Q);
    scl = 1'b0; wait_clk(2);
  endtask

  // ends with SCL high inside the acknowledge bit
  task automatic tx_byte(logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    ack = ~sda_line;
  endtask

  task automatic end_ack();
    scl = 1'b0; wait_clk(Q);
  endtask

  task automatic send_addr(logic [6:0] a, logic rw, output logic ack);
    i2c_start();
    tx_byte({a, rw}, ack);
    end_ack();
  endtask

  task automatic write_byte(logic [7:0] d);
    logic ack;
    tx_byte(d, ack);
    end_ack();
  endtask

  task automatic read_byte(logic m_ack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(Q);
      scl = 1'b1; wait_clk(Q);
      d = {d[6:0], sda_line};
      scl = 1'b0; wait_clk(2);
    end
    sda_m = ~m_ack; wait_clk(Q);
    scl = 1'b1;     wait_clk(Q);
    scl = 1'b0;     wait_clk(2);
    sda_m = 1'b1;   wait_clk(Q);
  endtask

  task automatic write_pair(logic [7:0] b0, logic [7:0] b1);
    logic ack;
    send_addr(ADDR, 1'b0, ack);
    write_byte(b0);
    write_byte(b1);
    i2c_stop();
  endtask

  task automatic t_reset();
    check("R1 drive_low", drive_low, 16'h0000);
    check("R1 strong_pu", strong_pu, 16'h0000);
    check("R1 sda_oe", {15'd0, sda_oe}, 16'h0000);
  endtask

  task automatic t_wrong_addr();
    logic ack;
    send_addr(ADDR ^ 7'h01, 1'b0, ack);
    check("R2 no ack", {15'd0, ack}, 16'h0000);
    tx_byte(8'h00, ack);
    check("R2 no data ack", {15'd0, ack}, 16'h0000);
    end_ack();
    i2c_stop();
    check("R2 ports unchanged", drive_low, 16'h0000);
  endtask

  task automatic t_write_pair();
    logic ack;
    send_addr(ADDR, 1'b0, ack);
    check("R2 ack", {15'd0, ack}, 16'h0001);
    tx_byte(8'hA5, ack);
    check("R4 before ack fall", drive_low, 16'h0000);
    end_ack();
    check("R4 R3 port0 first", drive_low, {8'h00, ~8'hA5});
    check("R6 pulse on ones", strong_pu, 16'h00A5);
    tx_byte(8'h3C, ack);
    check("R6 pulse ended", strong_pu, 16'h0000);
    end_ack();
    check("R3 R7 pair", drive_low, ~16'h3CA5);
    check("R6 pulse port1", strong_pu, 16'h3C00);
    i2c_stop();
  endtask

  task automatic t_long_write();
    logic ack;
    send_addr(ADDR, 1'b0, ack);
    write_byte(8'h11);
    write_byte(8'h22);
    write_byte(8'h33);
    check("R5 third to port0", drive_low, ~16'h2233);
    write_byte(8'h44);
    check("R5 fourth to port1", drive_low, ~16'h4433);
    i2c_stop();
  endtask

  task automatic t_ptr_reset();
    logic ack;
    send_addr(ADDR, 1'b0, ack);
    write_byte(8'hF0);
    i2c_stop();
    send_addr(ADDR, 1'b0, ack);
    write_byte(8'h0F);
    check("R9 stop resets pointer", drive_low, ~16'h440F);
    i2c_stop();
    send_addr(ADDR, 1'b0, ack);
    write_byte(8'hAA);
    send_addr(ADDR, 1'b0, ack);
    write_byte(8'h55);
    check("R9 restart resets pointer", drive_low, ~16'h4455);
    i2c_stop();
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    write_pair(8'hFF, 8'hFF);
    ext_pins = 16'h1234;
    send_addr(ADDR, 1'b1, ack);
    check("R8 read ack", {15'd0, ack}, 16'h0001);
    read_byte(1'b1, d); check("R8 byte0 port0", {8'h00, d}, 16'h0034);
    read_byte(1'b1, d); check("R8 byte1 port1", {8'h00, d}, 16'h0012);
    read_byte(1'b1, d); check("R8 byte2 port0", {8'h00, d}, 16'h0034);
    read_byte(1'b0, d); check("R8 byte3 port1", {8'h00, d}, 16'h0012);
    check("R8 sda released", {15'd0, sda_oe}, 16'h0000);
    i2c_stop();
    ext_pins = 16'hFFFF;
  endtask

  task automatic t_read_low();
    logic ack;
    logic [7:0] d;
    write_pair(8'h00, 8'hFF);
    send_addr(ADDR, 1'b1, ack);
    read_byte(1'b1, d); check("R7 low line reads 0", {8'h00, d}, 16'h0000);
    read_byte(1'b0, d); check("R7 high line reads 1", {8'h00, d}, 16'h00FF);
    i2c_stop();
  endtask

  task automatic t_sample_at_load();
    logic ack;
    logic [7:0] d;
    write_pair(8'hFF, 8'hFF);
    ext_pins = 16'hFFFF;
    send_addr(ADDR, 1'b1, ack);
    ext_pins = 16'h0F0F;  // after port0 byte is loaded
    read_byte(1'b1, d); check("R10 loaded byte kept", {8'h00, d}, 16'h00FF);
    read_byte(1'b0, d); check("R10 later byte sees change", {8'h00, d}, 16'h000F);
    i2c_stop();
    ext_pins = 16'hFFFF;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait_clk(WDOG);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_wrong_addr();
    t_write_pair();
    t_long_write();
    t_ptr_reset();
    t_read();
    t_read_low();
    t_sample_at_load();
    report();
  end
endmodule